// File: doc/BRIEF.md
# Speech Frame Preemphasis and Autocorrelation Engine

This block takes one frame of `N` signed fixed-point speech samples and returns the thirteen autocorrelation values r(0) through r(12) of that frame. Each accepted sample first goes through a first-order difference filter that lifts the high frequencies: the previous sample, scaled by 0.9375, is subtracted from it. The result is then weighted by a raised-cosine (Hamming) taper, whose coefficients come from an on-chip table with one entry per sample position. The tapered sample is written into a local frame buffer. Once the frame is complete, one multiply-accumulate datapath computes the lagged products lag by lag.

A frame begins with a one-cycle `frame_start` pulse while the engine is idle. Samples then arrive on a valid/ready stream. After the `N`-th sample the stream is closed and the engine computes the sums. Each finished lag is presented for one cycle with its lag number, and a one-cycle `done` follows the last lag. The controller is a five-state machine. IDLE waits for the start pulse and moves to FILL. FILL accepts samples and moves to MAC after the last one. MAC accumulates one product per cycle and moves to EMIT after the last product of the current lag. EMIT presents the result and returns to MAC for the next lag, or moves to DONE after lag 12. DONE raises the completion flag and returns to IDLE.

Number formats are two's complement throughout. The input sample has 15 fraction bits. The filtered sample has 15 fraction bits and one more integer bit. Taper coefficients are unsigned with 16 fraction bits. Tapered samples keep 20 fraction bits. Results carry 31 fraction bits.

Top module: `frame_autocorr`

## Requirements
- R1: The filtered sample is p(m) = s(m) − s(m−1) + (s(m−1) >>> 4), an arithmetic shift. s(m−1) is taken as zero for the first sample after `frame_start`, so no sample from a previous frame leaks into the new one.
- R2: The coefficient for position m is round((0.54 − 0.46·cos(2πm/(N−1)))·2^16). The tapered sample is (p(m)·coefficient) >>> 11, an arithmetic shift that keeps 20 fraction bits.
- R3: For each lag k from 0 to 12, `out_r` equals (Σ over m = 0 … N−1−k of x(m)·x(m+k)) >>> 9, where x is the tapered sample. Results leave in increasing lag order, and `out_lag` carries k in the same cycle as `out_valid`.
- R4: A result above 2^35−1 is output as 2^35−1, and a result below −2^35 is output as −2^35 (the `out_r` width is 36).
- R5: `done` is high for exactly one cycle, in the cycle right after the cycle in which lag 12 was presented, and at no other time.
- R6: `in_ready` is high only in the FILL state. Exactly N samples are taken per frame. Samples offered after the N-th one are not accepted and have no effect on the results.
- R7: A `frame_start` pulse while the engine is not idle is ignored: the stream stays closed, and the running frame's results are unchanged.
- R8: While `rst_n` is low, `in_ready`, `out_valid` and `done` are all low.
- R9: Idle cycles between samples on the stream (with `in_valid` low) do not change the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse that opens a new frame while idle |
| in_valid | input | 1 | Sample on `in_sample` is valid |
| in_ready | output | 1 | Engine accepts a sample this cycle |
| in_sample | input | SW (16) | Signed speech sample, 15 fraction bits |
| out_valid | output | 1 | `out_r` and `out_lag` hold a result |
| out_lag | output | LW (4) | Lag index k of the presented result |
| out_r | output | RW (36) | Saturated r(k), 31 fraction bits |
| done | output | 1 | One-cycle flag after r(12) |

## Verification
A wrong previous-sample register shows up first in r(1), which then differs from the expected value. This is clearest for an impulse frame, where only r(0) and r(1) may be non-zero, so the error is visible within one frame of lag results. A miscounted fill index or a bad window table address corrupts r(0) of that same frame, and a stale accumulator or a wrong lag counter corrupts the next presented value or its lag number. A controller that returns to the wrong state shows up at the ports as a missing or misplaced `done`, or as `in_ready` reopening while results are still pending. Both are seen within a cycle of the last lag.

// File: rtl/ac_pkg.sv
package ac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_MAC,
        ST_EMIT,
        ST_DONE
    } ac_state_e;

    // Raised-cosine taper coefficient for position m of an n-point frame,
    // unsigned with frac fraction bits, rounded to nearest.
    function automatic int win_coef(input int m, input int n, input int frac);
        real ang;
        real w;
        ang = 2.0 * 3.14159265358979 * real'(m) / real'(n - 1);
        w   = 0.54 - 0.46 * $cos(ang);
        return $rtoi(w * (2.0 ** frac) + 0.5);
    endfunction

endpackage

// File: rtl/ac_preemph.sv
module ac_preemph #(
    parameter int SW = 16,
    parameter int PW = SW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 load,
    input  logic signed [SW-1:0] s_in,
    output logic signed [PW-1:0] p_out
);
    logic signed [SW-1:0] prev_q;
    logic signed [PW:0]   ext_s;
    logic signed [PW:0]   ext_p;
    logic signed [PW:0]   diff;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            prev_q <= '0;
        end else if (load) begin
            prev_q <= s_in;
        end
    end

    // 0.9375*x is formed as x - (x >>> 4); no multiplier needed
    always_comb begin
        ext_s = (PW + 1)'(s_in);
        ext_p = (PW + 1)'(prev_q);
        diff  = ext_s - ext_p + (ext_p >>> 4);
        p_out = diff[PW-1:0];
    end

endmodule

// File: rtl/ac_window.sv
module ac_window #(
    parameter int N     = 32,
    parameter int PW    = 17,
    parameter int WF    = 16,
    parameter int SHIFT = 11,
    parameter int XW    = 22,
    parameter int IW    = $clog2(N)
) (
    input  logic [IW-1:0]        idx,
    input  logic signed [PW-1:0] p_in,
    output logic signed [XW-1:0] x_out
);
    localparam int CW  = WF + 1;
    localparam int PRW = PW + CW + 1;

    logic [CW-1:0]         coef_rom [N];
    logic signed [PRW-1:0] pa;
    logic signed [PRW-1:0] ca;
    logic signed [PRW-1:0] prod;
    logic signed [PRW-1:0] scaled;

    for (genvar g = 0; g < N; g++) begin : g_rom
        assign coef_rom[g] = CW'(ac_pkg::win_coef(g, N, WF));
    end

    always_comb begin
        pa     = PRW'(p_in);
        ca     = PRW'({1'b0, coef_rom[idx]});
        prod   = pa * ca;
        scaled = prod >>> SHIFT;
        x_out  = scaled[XW-1:0];
    end

endmodule

// File: rtl/ac_frame_buf.sv
module ac_frame_buf #(
    parameter int N  = 32,
    parameter int XW = 22,
    parameter int IW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_addr,
    input  logic signed [XW-1:0] wr_data,
    input  logic [IW-1:0]        rd_a,
    input  logic [IW-1:0]        rd_b,
    output logic signed [XW-1:0] q_a,
    output logic signed [XW-1:0] q_b
);
    logic signed [XW-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign q_a = mem[rd_a];
    assign q_b = mem[rd_b];

endmodule

// File: rtl/ac_lag_mac.sv
module ac_lag_mac #(
    parameter int XW    = 22,
    parameter int AW    = 49,
    parameter int RW    = 36,
    parameter int SHIFT = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 en,
    input  logic signed [XW-1:0] a,
    input  logic signed [XW-1:0] b,
    output logic signed [RW-1:0] r_out
);
    localparam logic signed [AW-1:0] RMAX = {{(AW-RW+1){1'b0}}, {(RW-1){1'b1}}};
    localparam logic signed [AW-1:0] RMIN = {{(AW-RW+1){1'b1}}, {(RW-1){1'b0}}};

    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] ea;
    logic signed [AW-1:0] eb;
    logic signed [AW-1:0] prod;
    logic signed [AW-1:0] shifted;

    always_comb begin
        ea   = AW'(a);
        eb   = AW'(b);
        prod = ea * eb;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= acc_q + prod;
        end
    end

    always_comb begin
        shifted = acc_q >>> SHIFT;
        if (shifted > RMAX) begin
            r_out = RMAX[RW-1:0];
        end else if (shifted < RMIN) begin
            r_out = RMIN[RW-1:0];
        end else begin
            r_out = shifted[RW-1:0];
        end
    end

endmodule

// File: rtl/frame_autocorr.sv
module frame_autocorr #(
    parameter int N      = 32,
    parameter int SW     = 16,
    parameter int SF     = 15,
    parameter int WF     = 16,
    parameter int XF     = 20,
    parameter int RF     = 31,
    parameter int RW     = 36,
    parameter int MAXLAG = 12,
    parameter int LW     = $clog2(MAXLAG + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [SW-1:0] in_sample,
    output logic                 out_valid,
    output logic [LW-1:0]        out_lag,
    output logic signed [RW-1:0] out_r,
    output logic                 done
);
    import ac_pkg::*;

    localparam int PW  = SW + 1;
    localparam int IW  = $clog2(N);
    localparam int XW  = XF + 2;
    localparam int WSH = SF + WF - XF;
    localparam int AW  = 2 * XW + $clog2(N);
    localparam int RSH = 2 * XF - RF;

    ac_state_e state_q, state_d;

    logic [IW-1:0]        wr_idx_q;
    logic [IW-1:0]        m_q;
    logic [LW-1:0]        lag_q;
    logic [IW-1:0]        last_m;
    logic [IW-1:0]        rd_b;
    logic                 accept;
    logic                 fill_last;
    logic                 mac_last;
    logic                 lag_last;
    logic                 start_ok;
    logic                 mac_clear;
    logic signed [PW-1:0] p_val;
    logic signed [XW-1:0] x_val;
    logic signed [XW-1:0] q_a;
    logic signed [XW-1:0] q_b;
    logic signed [RW-1:0] r_val;

    // ---------------- control conditions ----------------
    always_comb begin
        start_ok  = (state_q == ST_IDLE) && frame_start;
        accept    = (state_q == ST_FILL) && in_valid;
        fill_last = (wr_idx_q == IW'(N - 1));
        last_m    = IW'(N - 1) - IW'(lag_q);
        mac_last  = (m_q == last_m);
        lag_last  = (lag_q == LW'(MAXLAG));
        rd_b      = m_q + IW'(lag_q);
        mac_clear = (accept && fill_last) || ((state_q == ST_EMIT) && !lag_last);
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (frame_start)            state_d = ST_FILL;
            ST_FILL: if (accept && fill_last)    state_d = ST_MAC;
            ST_MAC:  if (mac_last)               state_d = ST_EMIT;
            ST_EMIT: state_d = lag_last ? ST_DONE : ST_MAC;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- counters ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx_q <= '0;
            m_q      <= '0;
            lag_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (frame_start) begin
                        wr_idx_q <= '0;
                    end
                end
                ST_FILL: begin
                    if (accept) begin
                        wr_idx_q <= wr_idx_q + 1'b1;
                        if (fill_last) begin
                            m_q   <= '0;
                            lag_q <= '0;
                        end
                    end
                end
                ST_MAC: begin
                    m_q <= m_q + 1'b1;
                end
                ST_EMIT: begin
                    if (!lag_last) begin
                        lag_q <= lag_q + 1'b1;
                        m_q   <= '0;
                    end
                end
                ST_DONE: begin
                    lag_q <= '0;
                    m_q   <= '0;
                end
                default: begin
                    m_q <= '0;
                end
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        in_ready  = (state_q == ST_FILL);
        out_valid = (state_q == ST_EMIT);
        done      = (state_q == ST_DONE);
        out_lag   = lag_q;
        out_r     = r_val;
    end

    // ---------------- datapath ----------------
    ac_preemph #(
        .SW (SW),
        .PW (PW)
    ) u_preemph (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start_ok),
        .load  (accept),
        .s_in  (in_sample),
        .p_out (p_val)
    );

    ac_window #(
        .N     (N),
        .PW    (PW),
        .WF    (WF),
        .SHIFT (WSH),
        .XW    (XW),
        .IW    (IW)
    ) u_window (
        .idx   (wr_idx_q),
        .p_in  (p_val),
        .x_out (x_val)
    );

    ac_frame_buf #(
        .N  (N),
        .XW (XW),
        .IW (IW)
    ) u_buf (
        .clk     (clk),
        .wr_en   (accept),
        .wr_addr (wr_idx_q),
        .wr_data (x_val),
        .rd_a    (m_q),
        .rd_b    (rd_b),
        .q_a     (q_a),
        .q_b     (q_b)
    );

    ac_lag_mac #(
        .XW    (XW),
        .AW    (AW),
        .RW    (RW),
        .SHIFT (RSH)
    ) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (mac_clear),
        .en    (state_q == ST_MAC),
        .a     (q_a),
        .b     (q_b),
        .r_out (r_val)
    );

endmodule

// File: rtl/frame_autocorr_chk.sv
module frame_autocorr_chk #(
    parameter int MAXLAG = 12,
    parameter int LW     = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          out_valid,
    input logic [LW-1:0] out_lag,
    input logic          done
);
    logic [LW-1:0] exp_lag;

    always_ff @(posedge clk) begin
        if (!rst_n || done) begin
            exp_lag <= '0;
        end else if (out_valid) begin
            exp_lag <= exp_lag + 1'b1;
        end
    end

    // R3
    lag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_lag == exp_lag);

    // R3
    emit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R5
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(out_valid) && $past(out_lag) == LW'(MAXLAG)));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!out_valid && !done));

    // R5
    last_lag_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_lag == LW'(MAXLAG)) |=> done);

endmodule

bind frame_autocorr frame_autocorr_chk #(
    .MAXLAG (MAXLAG),
    .LW     (LW)
) u_chk (.*);

// File: tb/tb_frame_autocorr.sv
module tb_frame_autocorr;
    localparam int CLK_PERIOD = 10;
    localparam int N      = 32;
    localparam int SW     = 16;
    localparam int RW     = 36;
    localparam int MAXLAG = 12;
    localparam int LW     = 4;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 frame_start;
    logic                 in_valid;
    logic                 in_ready;
    logic signed [SW-1:0] in_sample;
    logic                 out_valid;
    logic [LW-1:0]        out_lag;
    logic signed [RW-1:0] out_r;
    logic                 done;

    always #(CLK_PERIOD / 2) clk = ~clk;

    frame_autocorr #(.N(N), .SW(SW), .RW(RW), .MAXLAG(MAXLAG), .LW(LW)) dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
        .in_ready(in_ready), .in_sample(in_sample), .out_valid(out_valid),
        .out_lag(out_lag), .out_r(out_r), .done(done)
    );

    typedef struct {
        int     lag;
        longint val;
        string  tag;
    } exp_t;

    exp_t sbq[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   pend_done = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Reference model built from R1..R4
    function automatic void model(input int s[N], output longint r[MAXLAG+1]);
        longint x[N];
        longint prev;
        longint p;
        longint coef;
        longint acc;
        longint sh;
        longint rmax;
        rmax = (64'sd1 <<< (RW - 1)) - 1;
        prev = 0;
        for (int m = 0; m < N; m++) begin
            p    = longint'(s[m]) - prev + (prev >>> 4);
            coef = longint'($rtoi((0.54 - 0.46 * $cos(2.0 * 3.14159265358979 * real'(m) / real'(N - 1))) * 65536.0 + 0.5));
            x[m] = (p * coef) >>> 11;
            prev = longint'(s[m]);
        end
        for (int k = 0; k <= MAXLAG; k++) begin
            acc = 0;
            for (int m = 0; m < N - k; m++) acc += x[m] * x[m + k];
            sh = acc >>> 9;
            if (sh > rmax) sh = rmax;
            if (sh < -rmax - 1) sh = -rmax - 1;
            r[k] = sh;
        end
    endfunction

    // Monitor: pops expected results as the design presents them
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            if (pend_done) begin
                chk(done == 1'b1, "R5", "done after lag 12", longint'(done), 1);
                pend_done = 1'b0;
            end else if (done) begin
                chk(1'b0, "R5", "done at wrong time", 1, 0);
            end
            if (out_valid) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R3", "unexpected result", longint'(out_lag), -1);
                end else begin
                    e = sbq.pop_front();
                    chk(int'(out_lag) == e.lag, e.tag, "lag index", longint'(out_lag), longint'(e.lag));
                    chk(longint'(out_r) == e.val, e.tag, $sformatf("r(%0d)", e.lag),
                        longint'(out_r), e.val);
                    if (e.lag == MAXLAG) pend_done = 1'b1;
                end
            end
        end
    end

    // Driver: pushes expected items, then feeds one frame
    task automatic run_frame(input int s[N], input string tag, input bit gaps, input bit poke);
        longint r[MAXLAG+1];
        exp_t   e;
        model(s, r);
        for (int k = 0; k <= MAXLAG; k++) begin
            e.lag = k;
            e.val = r[k];
            e.tag = tag;
            sbq.push_back(e);
        end
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int m = 0; m < N; m++) begin
            bit taken;
            taken = 1'b0;
            while (!taken) begin
                @(negedge clk);
                in_valid  = 1'b1;
                in_sample = SW'(s[m]);
                taken     = in_ready;
                @(posedge clk);
            end
            if (gaps) begin
                @(negedge clk);
                in_valid  = 1'b0;
                in_sample = 16'sh7fff;
                @(posedge clk);
            end
        end
        // Extra samples after the N-th must be refused (R6)
        @(negedge clk);
        chk(in_ready == 1'b0, "R6", "ready after N samples", longint'(in_ready), 0);
        in_valid  = 1'b1;
        in_sample = 16'sh7fff;
        @(negedge clk);
        in_valid = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            frame_start = 1'b1;
            @(negedge clk);
            frame_start = 1'b0;
            chk(in_ready == 1'b0, "R7", "ready after busy start", longint'(in_ready), 0);
        end
        do @(negedge clk); while (!done);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int fr[N];
        rst_n       = 1'b0;
        frame_start = 1'b0;
        in_valid    = 1'b0;
        in_sample   = '0;
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0,  "R8", "in_ready in reset",  longint'(in_ready), 0);
        chk(out_valid == 1'b0, "R8", "out_valid in reset", longint'(out_valid), 0);
        chk(done == 1'b0,      "R8", "done in reset",      longint'(done), 0);
        rst_n = 1'b1;

        // R1: impulse; only r(0), r(1) non-zero if the history starts at zero
        foreach (fr[m]) fr[m] = 0;
        fr[0] = 16384;
        run_frame(fr, "R1", 1'b0, 1'b0);

        // R2: constant level; result shaped by the taper
        foreach (fr[m]) fr[m] = 12000;
        run_frame(fr, "R2", 1'b0, 1'b0);

        // R1: impulse again right after a non-zero frame (no leakage)
        foreach (fr[m]) fr[m] = 0;
        fr[0] = -20000;
        run_frame(fr, "R1", 1'b0, 1'b0);

        // R3: irregular pattern
        foreach (fr[m]) fr[m] = 4 * (((m * 7919) % 4001) - 2000);
        run_frame(fr, "R3", 1'b0, 1'b0);

        // R4: full-scale alternation drives both saturation bounds
        foreach (fr[m]) fr[m] = (m % 2 == 0) ? 32767 : -32768;
        run_frame(fr, "R4", 1'b0, 1'b0);

        // R9: same pattern with idle cycles between samples
        foreach (fr[m]) fr[m] = 4 * (((m * 7919) % 4001) - 2000);
        run_frame(fr, "R9", 1'b1, 1'b0);

        // R7: start pulse while computing
        foreach (fr[m]) fr[m] = 3000 * ((m % 5) - 2);
        run_frame(fr, "R7", 1'b0, 1'b1);

        repeat (5) @(negedge clk);
        chk(sbq.size() == 0, "R3", "results outstanding", longint'(sbq.size()), 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule